// File: doc/BRIEF.md
# FIFO Threshold Offset Register File

This block stores the two thresholds that a FIFO status-flag unit compares against its fill level. The almost-empty level n and the almost-full level m are each split into a byte-wide low register and a narrow high register, which gives four registers in all. Software loads them one byte at a time through the FIFO's own data input while a configuration-select line is held low. It reads them back through the FIFO's data output in the same way.

There is no address. A single two-bit ring selector points at one register and steps to the next after every completed access, whether a read or a write. It visits empty-low, empty-high, full-low, full-high and then wraps. The selector keeps its position while configuration-select is high, so a later session resumes where the last one stopped. The assembled n and m values are driven out continuously to the flag logic.

All offset traffic is timed by one access clock. The FIFO is expected to run its write and read sides from a common clock while it programs or inspects the thresholds.

Top module: `fifo_threshold_regs`

## Requirements
- R1: Reset (rst_n low, asynchronous) sets both levels to 7, points the selector at empty-low, clears q to 0 and clears access_clash.
- R2: With cfg_sel_n=0 and wr_n=0, each rising clk edge stores d into the selected register and advances the selector. The order is empty-low (bits 7:0 of n), empty-high (bits PW-1:8 of n), full-low (bits 7:0 of m), full-high (bits PW-1:8 of m), and then it wraps to empty-low.
- R3: While cfg_sel_n=1 the selector and all four registers hold. The next configuration access continues at the register that follows the last one accessed.
- R4: With cfg_sel_n=0, rd_a_n=0, rd_b_n=0 and wr_n=1, each rising clk edge loads the selected register onto q and advances the selector, in the same order as in R2.
- R5: If either read enable is high, no offset read occurs: q and the selector hold.
- R6: fifo_wr is high exactly when cfg_sel_n=1 and wr_n=0. Such a write leaves the offset registers and the selector unchanged. With wr_n=1 no write occurs at all.
- R7: If an offset write and an offset read are requested on the same edge, the write is performed and the selector advances once. q holds, and access_clash is high for the following cycle only. At all other times it is low.
- R8: A high register keeps only PW-8 bits (4 with defaults): the upper bits of d are ignored. Reading a high register returns those bits with zeros above them.
- R9: almost_empty_lvl equals {empty-high, empty-low} and almost_full_lvl equals {full-high, full-low} at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Access clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_sel_n | input | 1 | Low selects the offset registers instead of FIFO memory |
| wr_n | input | 1 | Write enable, active low |
| rd_a_n | input | 1 | First read enable, active low |
| rd_b_n | input | 1 | Second read enable, active low |
| d | input | DW | Write data |
| q | output | DW | Read-back data of the last offset read |
| fifo_wr | output | 1 | Write is routed to FIFO memory |
| almost_empty_lvl | output | PW | Threshold n |
| almost_full_lvl | output | PW | Threshold m |
| access_clash | output | 1 | Previous edge had a simultaneous offset read and write |

## Verification
The hardest state to reach is a selector position that is out of step with any session boundary: a simultaneous read and write, or a partial session, shifts every later access by one register. The bench gets there with directed partial sessions and a deliberate clash. It then applies a long pseudo-random stream in which cfg_sel_n is mostly low and the enables toggle freely, so that the selector walks through every phase under every command mix. A bench model of the ring and the registers predicts q and both levels after each edge.

// File: rtl/fifo_threshold_pkg.sv
package fifo_threshold_pkg;

  typedef enum logic [1:0] {
    SEL_E_LO = 2'd0,
    SEL_E_HI = 2'd1,
    SEL_F_LO = 2'd2,
    SEL_F_HI = 2'd3
  } ofs_sel_e;

  // ring order: next register after s, wrapping after full-high
  function automatic ofs_sel_e sel_next(input ofs_sel_e s);
    return ofs_sel_e'(s + 2'd1);
  endfunction

  // bit 0 of the selector marks a high-part register
  function automatic logic sel_is_hi(input ofs_sel_e s);
    return s[0];
  endfunction

  // bit 1 of the selector picks the full-side pair
  function automatic logic sel_pair(input ofs_sel_e s);
    return s[1];
  endfunction

endpackage

// File: rtl/ofs_sel_ring.sv
module ofs_sel_ring
  import fifo_threshold_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     adv,
  output ofs_sel_e sel
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sel <= SEL_E_LO;
    else if (adv) sel <= sel_next(sel);
  end

  p_sel_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(sel));

  p_sel_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (sel == sel_next($past(sel))));

endmodule

// File: rtl/ofs_regbank.sv
module ofs_regbank
  import fifo_threshold_pkg::*;
#(
  parameter int DW      = 8,
  parameter int PW      = 12,
  parameter int DEF_OFS = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_fire,
  input  logic          rd_fire,
  input  ofs_sel_e      sel,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q,
  output logic [PW-1:0] lvl_empty,
  output logic [PW-1:0] lvl_full
);

  localparam int HW = PW - DW;
  localparam logic [PW-1:0] DEF_V = PW'(DEF_OFS);

  logic [DW-1:0] lo_q [2];
  logic [HW-1:0] hi_q [2];
  logic [DW-1:0] rd_word;

  // zero-extend a high part to the data width
  function automatic logic [DW-1:0] widen_hi(input logic [HW-1:0] h);
    return {{(DW-HW){1'b0}}, h};
  endfunction

  for (genvar g = 0; g < 2; g++) begin : g_pair
    logic wr_lo;
    logic wr_hi;
    assign wr_lo = wr_fire && (sel_pair(sel) == 1'(g)) && !sel_is_hi(sel);
    assign wr_hi = wr_fire && (sel_pair(sel) == 1'(g)) &&  sel_is_hi(sel);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q[g] <= DEF_V[DW-1:0];
        hi_q[g] <= DEF_V[PW-1:DW];
      end else begin
        if (wr_lo) lo_q[g] <= d;
        if (wr_hi) hi_q[g] <= d[HW-1:0];
      end
    end
  end

  always_comb begin
    if (sel_is_hi(sel)) rd_word = widen_hi(hi_q[sel_pair(sel)]);
    else                rd_word = lo_q[sel_pair(sel)];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= '0;
    else if (rd_fire) q <= rd_word;
  end

  assign lvl_empty = {hi_q[0], lo_q[0]};
  assign lvl_full  = {hi_q[1], lo_q[1]};

  p_q_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> $stable(q));

  p_hi_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && sel_is_hi(sel)) |=> (q[DW-1:HW] == '0));

  p_regs_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> ($stable(lvl_empty) && $stable(lvl_full)));

  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && sel == SEL_E_LO) |=> (lvl_empty[DW-1:0] == $past(d)));

endmodule

// File: rtl/fifo_threshold_regs.sv
module fifo_threshold_regs
  import fifo_threshold_pkg::*;
#(
  parameter int DW      = 8,
  parameter int PW      = 12,
  parameter int DEF_OFS = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_sel_n,
  input  logic          wr_n,
  input  logic          rd_a_n,
  input  logic          rd_b_n,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q,
  output logic          fifo_wr,
  output logic [PW-1:0] almost_empty_lvl,
  output logic [PW-1:0] almost_full_lvl,
  output logic          access_clash
);

  // named internal events
  logic     ofs_wr;
  logic     rd_req;
  logic     ofs_rd;
  logic     clash;
  logic     adv;
  ofs_sel_e sel;

  assign ofs_wr  = !cfg_sel_n && !wr_n;
  assign rd_req  = !cfg_sel_n && !rd_a_n && !rd_b_n;
  assign ofs_rd  = rd_req && !ofs_wr;
  assign clash   = rd_req && ofs_wr;
  assign adv     = ofs_wr || rd_req;
  assign fifo_wr = cfg_sel_n && !wr_n;

  ofs_sel_ring u_ring (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (adv),
    .sel   (sel)
  );

  ofs_regbank #(
    .DW      (DW),
    .PW      (PW),
    .DEF_OFS (DEF_OFS)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_fire   (ofs_wr),
    .rd_fire   (ofs_rd),
    .sel       (sel),
    .d         (d),
    .q         (q),
    .lvl_empty (almost_empty_lvl),
    .lvl_full  (almost_full_lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) access_clash <= 1'b0;
    else        access_clash <= clash;
  end

  p_clash_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clash |=> access_clash);

  p_no_clash_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !clash |=> !access_clash);

  p_clash_q_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clash |=> $stable(q));

  p_fifo_path_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |=> ($stable(almost_empty_lvl) && $stable(almost_full_lvl)));

endmodule

// File: tb/tb_fifo_threshold_regs.sv
module tb_fifo_threshold_regs;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int PW = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_sel_n, wr_n, rd_a_n, rd_b_n;
  logic [DW-1:0] d;
  logic [DW-1:0] q;
  logic          fifo_wr;
  logic [PW-1:0] almost_empty_lvl, almost_full_lvl;
  logic          access_clash;

  int n_vec = 0;
  int n_bad = 0;

  // reference model state
  logic [7:0] m_lo [2];
  logic [3:0] m_hi [2];
  int         m_sel;
  logic [7:0] m_q;
  logic       m_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  fifo_threshold_regs #(.DW(DW), .PW(PW), .DEF_OFS(7)) dut (
    .clk, .rst_n, .cfg_sel_n, .wr_n, .rd_a_n, .rd_b_n, .d, .q,
    .fifo_wr, .almost_empty_lvl, .almost_full_lvl, .access_clash
  );

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_lo[0] = 8'd7; m_lo[1] = 8'd7;
    m_hi[0] = 4'd0; m_hi[1] = 4'd0;
    m_sel = 0; m_q = 8'd0; m_err = 1'b0;
  endtask

  // one access cycle: drive, check fifo_wr, predict, clock, compare
  task automatic step(input logic ld, input logic w, input logic ra,
                      input logic rb, input logic [7:0] dv);
    logic mw, mr;
    cfg_sel_n = ld; wr_n = w; rd_a_n = ra; rd_b_n = rb; d = dv;
    #1;
    chk("R6", int'(fifo_wr), int'(ld & ~w));
    mw = !ld && !w;
    mr = !ld && !ra && !rb;
    if (mw) begin
      if (m_sel % 2 == 0) m_lo[m_sel/2] = dv;
      else                m_hi[m_sel/2] = dv[3:0];
    end else if (mr) begin
      m_q = (m_sel % 2 == 0) ? m_lo[m_sel/2] : {4'h0, m_hi[m_sel/2]};
    end
    if (mw || mr) m_sel = (m_sel + 1) % 4;
    m_err = mw && mr;
    @(posedge clk); #1;
    chk("R4", int'(q), int'(m_q));
    chk("R7", int'(access_clash), int'(m_err));
    chk("R9", int'(almost_empty_lvl), int'({m_hi[0], m_lo[0]}));
    chk("R9", int'(almost_full_lvl),  int'({m_hi[1], m_lo[1]}));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    rst_n = 1'b0; cfg_sel_n = 1'b1; wr_n = 1'b1; rd_a_n = 1'b1; rd_b_n = 1'b1; d = '0;
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    chk("R1", int'(almost_empty_lvl), 7);
    chk("R1", int'(almost_full_lvl), 7);
    chk("R1", int'(q), 0);
    chk("R1", int'(access_clash), 0);
    step(0, 1, 0, 0, 8'h00);
    chk("R1", int'(q), 7);
    step(0, 1, 0, 0, 8'h00);
    chk("R1", int'(q), 0);
    step(0, 1, 0, 0, 8'h00);
    step(0, 1, 0, 0, 8'h00);

    // R2 / R8: full session
    step(0, 0, 1, 1, 8'hA5);
    step(0, 0, 1, 1, 8'hFB);
    step(0, 0, 1, 1, 8'h3C);
    step(0, 0, 1, 1, 8'hF2);
    chk("R2", int'(almost_empty_lvl), 'hBA5);
    chk("R8", int'(almost_full_lvl), 'h23C);
    step(0, 1, 0, 0, 8'h00);
    chk("R4", int'(q), 'hA5);
    step(0, 1, 0, 0, 8'h00);
    chk("R8", int'(q), 'h0B);
    step(0, 1, 0, 0, 8'h00);
    step(0, 1, 0, 0, 8'h00);

    // R3: partial session resumes
    step(0, 0, 1, 1, 8'h11);
    step(1, 1, 1, 1, 8'h00);
    step(1, 1, 0, 0, 8'h00);
    step(1, 0, 1, 1, 8'h99);
    step(0, 0, 1, 1, 8'h05);
    chk("R3", int'(almost_empty_lvl), 'h511);
    step(0, 1, 0, 0, 8'h00);
    chk("R3", int'(q), 'h3C);

    // R5: one enable high means no read
    step(0, 1, 0, 1, 8'h00);
    step(0, 1, 1, 0, 8'h00);
    chk("R5", int'(q), 'h3C);
    step(0, 1, 0, 0, 8'h00);
    chk("R5", int'(q), 'h02);

    // R7: clash at empty-low
    step(0, 0, 0, 0, 8'h22);
    chk("R7", int'(access_clash), 1);
    chk("R7", int'(q), 'h02);
    chk("R7", int'(almost_empty_lvl), 'h522);
    step(1, 1, 1, 1, 8'h00);
    chk("R7", int'(access_clash), 0);
    step(0, 1, 0, 0, 8'h00);
    chk("R7", int'(q), 'h05);

    // R6: FIFO-path writes leave thresholds alone
    step(1, 0, 1, 1, 8'hFF);
    step(1, 0, 0, 0, 8'hEE);
    chk("R6", int'(almost_empty_lvl), 'h522);
    chk("R6", int'(almost_full_lvl), 'h23C);

    // sweep every command combination over several data values
    for (int k = 0; k < 256; k++) begin
      logic [3:0] c;
      c = k[3:0];
      step(c[3], c[2], c[1], c[0], 8'(k * 37 + 11));
    end

    // long pseudo-random stream, configuration mostly selected
    lfsr = 16'hACE1;
    for (int k = 0; k < 3000; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[1] & lfsr[0], lfsr[2], lfsr[3], lfsr[4], lfsr[15:8]);
    end

    // R1: reset mid-run restores defaults and the ring start
    rst_n = 1'b0; #1;
    model_reset();
    chk("R1", int'(almost_empty_lvl), 7);
    chk("R1", int'(almost_full_lvl), 7);
    @(posedge clk); #1 rst_n = 1'b1;
    step(0, 0, 1, 1, 8'h44);
    chk("R1", int'(almost_empty_lvl), 'h044);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule